// File: doc/BRIEF.md
# Serial-Poll Status and Service-Request Unit

This block sits between a parallel instrument-bus interface and a serial-port bridge. Every cycle it turns the fill levels of two buffers into a registered 8-bit status byte. The first buffer carries data from the bus to the serial side, and the second carries data from the serial side to the bus. The bus handshake logic returns this byte when the controller serial-polls the device. The unit does not touch either buffer, so a poll never stalls or changes the data moving through them.

When service requests are enabled and a serial terminator character arrives, the unit latches a request. The request drives the bus service-request line and raises two status bits. The request stays latched until the controller polls the device. A poll clears it one cycle after the poll strobe, so the byte returned during the poll still shows the request. A terminator that arrives in the same cycle as a poll sets the request again. Turning the enable off drops a pending request.

Top module: `spoll_status_unit`

## Requirements
- R1: Status bit 7 is 1 exactly when the bus-to-serial occupancy count was non-zero in the previous cycle.
- R2: Status bit 3 is 1 when the bus-to-serial free space in the previous cycle (DEPTH minus occupancy, floored at 0; defaults DEPTH=4096 and LOW_MARK=1280) was LOW_MARK or less. With the defaults this means occupancy of 2816 or more.
- R3: Status bit 4 is 1 exactly when the serial-to-bus occupancy count was non-zero in the previous cycle.
- R4: When `srq_enable` is high and `term_seen` is high on a clock edge, then after that edge `srq_out`, status bit 6 and status bit 2 are all 1.
- R5: A latched request stays set, with `srq_out` and bits 6 and 2 at 1, through any number of cycles without a poll while the enable stays high.
- R6: The status byte seen during the `poll_strobe` cycle still shows bits 6 and 2 set. After that edge, `srq_out` and bits 6 and 2 are 0, unless R7 applies.
- R7: A terminator in the same cycle as a poll, with the enable high, leaves the request set after the edge.
- R8: While `srq_enable` is low, `term_seen` changes neither `srq_out` nor any status bit.
- R9: Taking `srq_enable` low while a request is latched clears `srq_out` and bits 6 and 2 on the next edge.
- R10: Status bits 5, 1 and 0 always read 0.
- R11: A synchronous active-high `rst` clears the status byte and the request, and releases `srq_out`.
- R12: A poll leaves status bits 7, 4 and 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_count | input | CNT_W (13) | Bus-to-serial buffer occupancy |
| rx_count | input | CNT_W (13) | Serial-to-bus buffer occupancy |
| term_seen | input | 1 | One-cycle strobe: serial terminator received |
| srq_enable | input | 1 | Static service-request enable |
| poll_strobe | input | 1 | One-cycle strobe: controller is serial-polling |
| status_byte | output | 8 | Registered serial-poll status byte |
| srq_out | output | 1 | Service-request line, active high |

## Verification
Two events can fall in the same cycle: a terminator that sets the request and a poll that clears it. The bench latches a request, then drives `term_seen` and `poll_strobe` together in one cycle. It expects the request to be set after the edge (R7), not cleared. A second case drops `srq_enable` while the request is latched, to check that the disable wins over the held state (R9). A third case polls while both buffers hold data, to check that the buffer-level bits do not change across the poll (R12).

// File: rtl/spoll_pkg.sv
package spoll_pkg;

  // Bit positions inside the serial-poll byte; the bus side decodes them.
  localparam int unsigned BIT_TX_BUSY  = 7;
  localparam int unsigned BIT_SRQ_HI   = 6;
  localparam int unsigned BIT_RX_READY = 4;
  localparam int unsigned BIT_TX_LOW   = 3;
  localparam int unsigned BIT_SRQ_LO   = 2;

  typedef struct packed {
    logic tx_busy;
    logic tx_low;
    logic rx_ready;
  } level_flags_t;

  // Free locations left in a buffer of the given depth, floored at zero.
  function automatic int unsigned free_slots(input int unsigned depth,
                                             input int unsigned occ);
    if (occ >= depth) return 0;
    return depth - occ;
  endfunction

  // Low-space test: free space at or below the mark.
  function automatic logic is_low_space(input int unsigned depth,
                                        input int unsigned occ,
                                        input int unsigned mark);
    return free_slots(depth, occ) <= mark;
  endfunction

endpackage

// File: rtl/spoll_level_flags.sv
module spoll_level_flags
  import spoll_pkg::*;
#(
  parameter int unsigned DEPTH    = 4096,
  parameter int unsigned LOW_MARK = 1280,
  parameter int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  output level_flags_t     flags
);

  localparam int unsigned PAD_W = 32 - CNT_W;

  logic [31:0] tx_wide;
  assign tx_wide = {{PAD_W{1'b0}}, tx_count};

  always_comb begin
    flags.tx_busy  = |tx_count;
    flags.rx_ready = |rx_count;
    flags.tx_low   = is_low_space(DEPTH, tx_wide, LOW_MARK);
  end

endmodule

// File: rtl/spoll_srq_latch.sv
module spoll_srq_latch (
  input  logic clk,
  input  logic rst,
  input  logic srq_enable,
  input  logic term_seen,
  input  logic poll_strobe,
  output logic srq_q,
  output logic srq_next,
  output logic set_evt,
  output logic clr_evt
);

  // A set wins over a clear in the same cycle; a low enable wins over both.
  assign set_evt  = srq_enable & term_seen;
  assign clr_evt  = srq_q & (poll_strobe | ~srq_enable) & ~set_evt;
  assign srq_next = set_evt | (srq_q & ~clr_evt);

  always_ff @(posedge clk) begin
    if (rst) srq_q <= 1'b0;
    else     srq_q <= srq_next;
  end

endmodule

// File: rtl/spoll_byte_pack.sv
module spoll_byte_pack
  import spoll_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  level_flags_t flags,
  input  logic         srq_bit,
  output logic [7:0]   status_q
);

  logic [7:0] status_d;

  always_comb begin
    status_d = '0;
    status_d[BIT_TX_BUSY]  = flags.tx_busy;
    status_d[BIT_SRQ_HI]   = srq_bit;
    status_d[BIT_RX_READY] = flags.rx_ready;
    status_d[BIT_TX_LOW]   = flags.tx_low;
    status_d[BIT_SRQ_LO]   = srq_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

endmodule

// File: rtl/spoll_status_unit.sv
module spoll_status_unit
  import spoll_pkg::*;
#(
  parameter int unsigned DEPTH    = 4096,
  parameter int unsigned LOW_MARK = 1280,
  parameter int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             term_seen,
  input  logic             srq_enable,
  input  logic             poll_strobe,
  output logic [7:0]       status_byte,
  output logic             srq_out
);

  level_flags_t lvl_flags;
  logic         srq_held;
  logic         srq_next;
  logic         srq_set_evt;
  logic         srq_clr_evt;

  spoll_level_flags #(
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .CNT_W(CNT_W)
  ) u_levels (
    .tx_count(tx_count),
    .rx_count(rx_count),
    .flags   (lvl_flags)
  );

  spoll_srq_latch u_srq (
    .clk        (clk),
    .rst        (rst),
    .srq_enable (srq_enable),
    .term_seen  (term_seen),
    .poll_strobe(poll_strobe),
    .srq_q      (srq_held),
    .srq_next   (srq_next),
    .set_evt    (srq_set_evt),
    .clr_evt    (srq_clr_evt)
  );

  // The byte register loads the request's next state, so bits 6/2 move
  // on the same edge as the line.
  spoll_byte_pack u_pack (
    .clk     (clk),
    .rst     (rst),
    .flags   (lvl_flags),
    .srq_bit (srq_next),
    .status_q(status_byte)
  );

  assign srq_out = srq_held;

endmodule

// File: rtl/spoll_status_checker.sv
module spoll_status_checker #(
  parameter int unsigned DEPTH    = 4096,
  parameter int unsigned LOW_MARK = 1280,
  parameter int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             term_seen,
  input logic             srq_enable,
  input logic             poll_strobe,
  input logic [7:0]       status_byte,
  input logic             srq_out,
  input logic             set_evt,
  input logic             clr_evt
);

  assert_tx_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_count != '0) |=> status_byte[7]);

  assert_tx_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_count == '0) |=> !status_byte[7]);

  assert_low_space_R2: assert property (@(posedge clk) disable iff (rst)
    ((int'(tx_count) + int'(LOW_MARK)) >= int'(DEPTH)) |=> status_byte[3]);

  assert_rx_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_count != '0) |=> status_byte[4]);

  assert_srq_set_R4: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> (srq_out && status_byte[6] && status_byte[2]));

  assert_srq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (srq_out && srq_enable && !poll_strobe) |=> srq_out);

  assert_srq_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && poll_strobe) |=> (!srq_out && !status_byte[6]));

  assert_srq_collide_R7: assert property (@(posedge clk) disable iff (rst)
    (poll_strobe && term_seen && srq_enable) |=> srq_out);

  assert_srq_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !srq_enable |=> (!srq_out && !status_byte[2]));

  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (rst)
    srq_enable |=> (status_byte[5] == 1'b0 && status_byte[1:0] == 2'b00));

  assert_srq_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    srq_enable |=> (status_byte[6] == srq_out));

endmodule

bind spoll_status_unit spoll_status_checker #(
  .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .CNT_W(CNT_W)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .tx_count   (tx_count),
  .rx_count   (rx_count),
  .term_seen  (term_seen),
  .srq_enable (srq_enable),
  .poll_strobe(poll_strobe),
  .status_byte(status_byte),
  .srq_out    (srq_out),
  .set_evt    (srq_set_evt),
  .clr_evt    (srq_clr_evt)
);

// File: tb/spoll_status_unit_bench.sv
module spoll_status_unit_bench;

  localparam int unsigned CNT_W = 13;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] tx_count = '0;
  logic [CNT_W-1:0] rx_count = '0;
  logic             term_seen = 1'b0;
  logic             srq_enable = 1'b0;
  logic             poll_strobe = 1'b0;
  logic [7:0]       status_byte;
  logic             srq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spoll_status_unit u_spoll_status_unit (
    .clk        (clk),
    .rst        (rst),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .term_seen  (term_seen),
    .srq_enable (srq_enable),
    .poll_strobe(poll_strobe),
    .status_byte(status_byte),
    .srq_out    (srq_out)
  );

  typedef struct packed {
    logic [12:0] tx;
    logic [12:0] rx;
    logic [7:0]  exp;
  } vec_t;

  // Level vectors with no request pending: bit7 busy, bit4 rx, bit3 low.
  localparam vec_t VECS [8] = '{
    '{tx: 13'd0,    rx: 13'd0,    exp: 8'h00},
    '{tx: 13'd1,    rx: 13'd0,    exp: 8'h80},
    '{tx: 13'd0,    rx: 13'd5,    exp: 8'h10},
    '{tx: 13'd2815, rx: 13'd0,    exp: 8'h80},
    '{tx: 13'd2816, rx: 13'd0,    exp: 8'h88},
    '{tx: 13'd4096, rx: 13'd1,    exp: 8'h98},
    '{tx: 13'd2817, rx: 13'd4096, exp: 8'h98},
    '{tx: 13'd3000, rx: 13'd0,    exp: 8'h88}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic latch_request();
    srq_enable = 1'b1;
    term_seen  = 1'b1;
    tick();
    term_seen  = 1'b0;
  endtask

  initial begin
    tick();
    tick();
    check("R11 reset status", status_byte, 8'h00);
    check("R11 reset srq", {7'd0, srq_out}, 8'h00);
    rst = 1'b0;

    // Level table: R1, R2, R3, R10
    for (int i = 0; i < 8; i++) begin
      tx_count = VECS[i].tx;
      rx_count = VECS[i].rx;
      tick();
      check("R1/R2/R3 level vector", status_byte, VECS[i].exp);
      check("R10 zero bits", status_byte & 8'h23, 8'h00);
    end
    tx_count = '0;
    rx_count = '0;
    tick();

    // R4 set, R5 hold
    latch_request();
    check("R4 srq set", {7'd0, srq_out}, 8'h01);
    check("R4 status bits", status_byte, 8'h44);
    tick(); tick(); tick();
    check("R5 held", status_byte, 8'h44);
    check("R5 line held", {7'd0, srq_out}, 8'h01);

    // R6 poll: value during poll cycle, then cleared
    poll_strobe = 1'b1;
    check("R6 poll cycle shows request", status_byte, 8'h44);
    tick();
    poll_strobe = 1'b0;
    check("R6 cleared status", status_byte, 8'h00);
    check("R6 cleared line", {7'd0, srq_out}, 8'h00);

    // R7 collision
    latch_request();
    poll_strobe = 1'b1;
    term_seen   = 1'b1;
    tick();
    poll_strobe = 1'b0;
    term_seen   = 1'b0;
    check("R7 collide line", {7'd0, srq_out}, 8'h01);
    check("R7 collide status", status_byte, 8'h44);
    poll_strobe = 1'b1;
    tick();
    poll_strobe = 1'b0;

    // R8 disabled terminator
    srq_enable = 1'b0;
    term_seen  = 1'b1;
    tick();
    term_seen  = 1'b0;
    check("R8 disabled status", status_byte, 8'h00);
    check("R8 disabled line", {7'd0, srq_out}, 8'h00);
    tick();
    check("R8 disabled later", status_byte, 8'h00);

    // R9 disable while latched
    latch_request();
    srq_enable = 1'b0;
    tick();
    check("R9 disable clears line", {7'd0, srq_out}, 8'h00);
    check("R9 disable clears status", status_byte, 8'h00);

    // R12 poll leaves level bits alone
    srq_enable = 1'b1;
    tx_count = 13'd2900;
    rx_count = 13'd3;
    tick();
    check("R12 before poll", status_byte, 8'h98);
    poll_strobe = 1'b1;
    tick();
    poll_strobe = 1'b0;
    check("R12 after poll", status_byte, 8'h98);

    // R11 reset while latched
    latch_request();
    check("R11 pre-reset latched", status_byte, 8'hDC);
    rst = 1'b1;
    tick();
    check("R11 reset status", status_byte, 8'h00);
    check("R11 reset line", {7'd0, srq_out}, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule